// File: doc/BRIEF.md
# Funnel-Based Shift, Rotate and Permute Unit

This block is a 32-bit datapath that produces every shift, rotate, funnel shift, bit-field operation and reversal from a single right-funnel network. The network has five stages and shifts a 64-bit pair {high, low} right by the shift amount. It then keeps the low word. Left-going operations reuse the same network: the operands are bit-mirrored on the way in and the result is mirrored on the way out. Zero fill, sign fill, rotation and funnel fill differ only in what is placed in the high word. That word is zero for zero fill, copies of A[31] for sign fill, A itself for rotation, and B for a funnel shift.

A mask/merge stage follows the network and adds two bit-field operations. Extract moves a field of A down to bit 0 and clears everything above its length. Insert moves the low bits of A up to a position and merges them into B. Byte and halfword reversals come from a separate wiring stage that only reorders bytes. One result register is selected by a parameter and is on by default, which gives a latency of one clock.

Top module: `shift_permute_unit`

## Requirements
- R1: While `rst_n` is low, `res_o` reads zero. After reset, with `OUT_REG=1`, the result for the inputs applied before a rising clock edge appears on `res_o` after that edge.
- R2: Opcode encoding: 0 SLL, 1 SRL, 2 SRA, 3 ROL, 4 ROR, 5 FSL, 6 FSR, 7 BEXT, 8 BINS, 9 bytes swapped within each halfword, 10 bytes reversed within the word, 11 halfwords swapped, 12 full bit reversal. Codes 13 to 15 give zero.
- R3: SLL and SRL fill vacated bits with zeros. SRA fills them with A[31]. The 5-bit amount n is used as is (taken modulo 32). For opcodes 0 to 6, n = 0 returns A.
- R4: ROL equals (A << n) | (A >> (32 - n)), and ROR equals (A >> n) | (A << (32 - n)). A shift by 32 gives zero.
- R5: FSL equals (A << n) | (B >> (32 - n)). With B = 0 it matches SLL, and with B = A it matches ROL.
- R6: FSR equals (A >> n) | (B << (32 - n)). With B = 0 it matches SRL, with B = A it matches ROR, and with B all copies of A[31] it matches SRA.
- R7: BEXT returns (A >> pos) & M. M has the low `len` bits set. A `len` of 32 or more sets all 32 bits of M, and a `len` of 0 gives zero. Field bits beyond bit 31 read as zero.
- R8: BINS returns (B & ~(M << pos)) | ((A << pos) & (M << pos)), with M as in R7. The mask is clipped at bit 31. A `len` of 0 returns B.
- R9: Each reversal opcode reorders A exactly. Code 9 maps byte k to byte k^1. Code 10 maps byte k to byte k^3. Code 11 maps byte k to byte k^2. Code 12 maps bit i to bit 31-i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code (R2) |
| a_i | input | 32 | Source operand A |
| b_i | input | 32 | Source operand B (fill or destination word) |
| amt_i | input | 5 | Shift amount for opcodes 0 to 6 |
| fpos_i | input | 5 | Bit-field position |
| flen_i | input | 6 | Bit-field length |
| res_o | output | 32 | Result |

## Verification
The bench targets amount zero and amount 31. A funnel that shifts by 32 - n without a zero guard returns A | B instead of A when n is zero. A network stage wired to the wrong power of two corrupts only certain amounts, and a sweep over all 32 amounts exposes it. Fields that cross bit 31 and lengths of 0, 32 and above 32 probe the mask builder; an off-by-one there leaks a bit into B or above the extracted field. Sign fill is checked against funnel fill by copies of A[31], and each reversal opcode is checked against a bench-side reordering, so a swapped byte index shows up at once.

// File: rtl/spu_pkg.sv
package spu_pkg;

    typedef enum logic [3:0] {
        OP_SLL    = 4'd0,
        OP_SRL    = 4'd1,
        OP_SRA    = 4'd2,
        OP_ROL    = 4'd3,
        OP_ROR    = 4'd4,
        OP_FSL    = 4'd5,
        OP_FSR    = 4'd6,
        OP_BEXT   = 4'd7,
        OP_BINS   = 4'd8,
        OP_REVB_H = 4'd9,
        OP_REVB_W = 4'd10,
        OP_REVH_W = 4'd11,
        OP_REV_BT = 4'd12
    } spu_op_e;

    typedef enum logic [1:0] {
        RK_BITS   = 2'd0,
        RK_B_IN_H = 2'd1,
        RK_B_IN_W = 2'd2,
        RK_H_IN_W = 2'd3
    } rev_kind_e;

    typedef enum logic [1:0] {
        SEL_ZERO  = 2'd0,
        SEL_NET   = 2'd1,
        SEL_FIELD = 2'd2,
        SEL_REV   = 2'd3
    } res_sel_e;

endpackage

// File: rtl/spu_funnel_net.sv
// Right funnel over the pair {hi, lo}: keeps the low W bits of {hi,lo} >> amt.
// With mirror_i set, operands are bit-mirrored before and after, which turns
// the same network into a left funnel.
module spu_funnel_net #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  hi_i,
    input  logic [W-1:0]  lo_i,
    input  logic [SW-1:0] amt_i,
    input  logic          mirror_i,
    output logic [W-1:0]  y_o
);

    localparam int PW = 2 * W;

    function automatic logic [W-1:0] mirror_word(input logic [W-1:0] x);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            r[i] = x[W-1-i];
        end
        return r;
    endfunction

    logic [W-1:0]  hi_in;
    logic [W-1:0]  lo_in;
    logic [PW-1:0] stage [0:SW];

    always_comb begin
        hi_in = mirror_i ? mirror_word(hi_i) : hi_i;
        lo_in = mirror_i ? mirror_word(lo_i) : lo_i;
    end

    assign stage[0] = {hi_in, lo_in};

    // one stage per amount bit, each moving by a fixed power of two
    for (genvar s = 0; s < SW; s++) begin : g_stage
        assign stage[s+1] = amt_i[s] ? (stage[s] >> (2 ** s)) : stage[s];
    end

    assign y_o = mirror_i ? mirror_word(stage[SW][W-1:0]) : stage[SW][W-1:0];

endmodule

// File: rtl/spu_field_merge.sv
// Builds the field mask from the length and either clears the bits above
// the field (extract) or merges the moved field into the destination (insert).
module spu_field_merge #(
    parameter int W  = 32,
    parameter int SW = $clog2(W),
    parameter int LW = SW + 1
) (
    input  logic [W-1:0]  net_i,
    input  logic [W-1:0]  dest_i,
    input  logic [SW-1:0] pos_i,
    input  logic [LW-1:0] len_i,
    input  logic          insert_i,
    output logic [W-1:0]  y_o
);

    logic [W-1:0] low_mask;
    logic [W-1:0] place_mask;
    logic [W-1:0] extracted;
    logic [W-1:0] inserted;

    always_comb begin
        if (len_i >= LW'(W)) begin
            low_mask = '1;
        end else begin
            low_mask = (W'(1) << len_i) - W'(1);
        end
        place_mask = low_mask << pos_i;
        extracted  = net_i & low_mask;
        inserted   = (dest_i & ~place_mask) | (net_i & place_mask);
        y_o        = insert_i ? inserted : extracted;
    end

endmodule

// File: rtl/spu_reverse.sv
// Fixed reorderings: every byte-granular one is a byte-index XOR with a
// constant, so each is pure wiring; bit order reversal is a full mirror.
module spu_reverse #(
    parameter int W = 32
) (
    input  logic [W-1:0]              a_i,
    input  spu_pkg::rev_kind_e        kind_i,
    output logic [W-1:0]              y_o
);
    import spu_pkg::*;

    localparam int NB = W / 8;

    logic [W-1:0] swap_bh;
    logic [W-1:0] swap_bw;
    logic [W-1:0] swap_hw;
    logic [W-1:0] flip_bits;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign swap_bh[8*g +: 8] = a_i[8*(g ^ 1) +: 8];
        assign swap_bw[8*g +: 8] = a_i[8*(g ^ 3) +: 8];
        assign swap_hw[8*g +: 8] = a_i[8*(g ^ 2) +: 8];
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign flip_bits[i] = a_i[W-1-i];
    end

    always_comb begin
        case (kind_i)
            RK_B_IN_H: y_o = swap_bh;
            RK_B_IN_W: y_o = swap_bw;
            RK_H_IN_W: y_o = swap_hw;
            default:   y_o = flip_bits;
        endcase
    end

endmodule

// File: rtl/shift_permute_unit.sv
module shift_permute_unit #(
    parameter int W       = 32,
    parameter bit OUT_REG = 1'b1,
    parameter int SW      = $clog2(W),
    parameter int LW      = SW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic [SW-1:0] amt_i,
    input  logic [SW-1:0] fpos_i,
    input  logic [LW-1:0] flen_i,
    output logic [W-1:0]  res_o
);
    import spu_pkg::*;

    typedef struct packed {
        logic [W-1:0] res;
    } out_st_t;

    out_st_t st_d, st_q;

    // network operand selection
    logic [W-1:0]  net_hi;
    logic [W-1:0]  net_lo;
    logic [SW-1:0] net_amt;
    logic          net_mirror;
    logic          fld_insert;
    rev_kind_e     rev_kind;
    res_sel_e      res_sel;

    logic [W-1:0]  net_y;
    logic [W-1:0]  fld_y;
    logic [W-1:0]  rev_y;

    always_comb begin
        net_hi     = '0;
        net_lo     = a_i;
        net_amt    = amt_i;
        net_mirror = 1'b0;
        fld_insert = 1'b0;
        rev_kind   = RK_BITS;
        res_sel    = SEL_ZERO;
        case (op_i)
            OP_SLL: begin
                net_mirror = 1'b1;
                res_sel    = SEL_NET;
            end
            OP_SRL: begin
                res_sel    = SEL_NET;
            end
            OP_SRA: begin
                net_hi     = {W{a_i[W-1]}};
                res_sel    = SEL_NET;
            end
            OP_ROL: begin
                net_hi     = a_i;
                net_mirror = 1'b1;
                res_sel    = SEL_NET;
            end
            OP_ROR: begin
                net_hi     = a_i;
                res_sel    = SEL_NET;
            end
            OP_FSL: begin
                net_hi     = b_i;
                net_mirror = 1'b1;
                res_sel    = SEL_NET;
            end
            OP_FSR: begin
                net_hi     = b_i;
                res_sel    = SEL_NET;
            end
            OP_BEXT: begin
                net_amt    = fpos_i;
                res_sel    = SEL_FIELD;
            end
            OP_BINS: begin
                net_amt    = fpos_i;
                net_mirror = 1'b1;
                fld_insert = 1'b1;
                res_sel    = SEL_FIELD;
            end
            OP_REVB_H: begin
                rev_kind   = RK_B_IN_H;
                res_sel    = SEL_REV;
            end
            OP_REVB_W: begin
                rev_kind   = RK_B_IN_W;
                res_sel    = SEL_REV;
            end
            OP_REVH_W: begin
                rev_kind   = RK_H_IN_W;
                res_sel    = SEL_REV;
            end
            OP_REV_BT: begin
                rev_kind   = RK_BITS;
                res_sel    = SEL_REV;
            end
            default: begin
                res_sel    = SEL_ZERO;
            end
        endcase
    end

    spu_funnel_net #(.W(W), .SW(SW)) u_net (
        .hi_i     (net_hi),
        .lo_i     (net_lo),
        .amt_i    (net_amt),
        .mirror_i (net_mirror),
        .y_o      (net_y)
    );

    spu_field_merge #(.W(W), .SW(SW), .LW(LW)) u_field (
        .net_i    (net_y),
        .dest_i   (b_i),
        .pos_i    (fpos_i),
        .len_i    (flen_i),
        .insert_i (fld_insert),
        .y_o      (fld_y)
    );

    spu_reverse #(.W(W)) u_rev (
        .a_i    (a_i),
        .kind_i (rev_kind),
        .y_o    (rev_y)
    );

    always_comb begin
        case (res_sel)
            SEL_NET:   st_d.res = net_y;
            SEL_FIELD: st_d.res = fld_y;
            SEL_REV:   st_d.res = rev_y;
            default:   st_d.res = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o = OUT_REG ? st_q.res : st_d.res;

    if (OUT_REG) begin : g_chk
        assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i >= 4'd13) |=> (res_o == '0));

        assert_amt0_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ((op_i <= 4'd6) && (amt_i == '0)) |=> (res_o == $past(a_i)));

        assert_ror_reference_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (op_i == OP_ROR) |=> (res_o == (($past(a_i) >> $past(amt_i)) |
                                            ($past(a_i) << (W - int'($past(amt_i)))))));

        assert_fsl_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ((op_i == OP_FSL) && (b_i == '0)) |=> (res_o == ($past(a_i) << $past(amt_i))));

        assert_fsr_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ((op_i == OP_FSR) && (b_i == '0)) |=> (res_o == ($past(a_i) >> $past(amt_i))));

        assert_bext_high_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((op_i == OP_BEXT) && (flen_i < LW'(W))) |=> ((res_o >> $past(flen_i)) == '0));

        assert_bins_empty_keeps_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ((op_i == OP_BINS) && (flen_i == '0)) |=> (res_o == $past(b_i)));

        assert_reverse_popcount_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ((op_i >= 4'd9) && (op_i <= 4'd12)) |=>
                ($countones(res_o) == $countones($past(a_i))));
    end

endmodule

// File: tb/tb_shift_permute_unit.sv
`timescale 1ns/1ps
module tb_shift_permute_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  op;
    logic [31:0] a, b;
    logic [4:0]  amt, pos;
    logic [5:0]  len;
    logic [31:0] res;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    shift_permute_unit dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
        .amt_i(amt), .fpos_i(pos), .flen_i(len), .res_o(res)
    );

    // {op, a, b, amt, pos, len, expected}
    localparam int NV = 20;
    localparam logic [115:0] VEC [0:NV-1] = '{
        {4'd0,  32'h0000_0001, 32'h0, 5'd4,  5'd0,  6'd0,  32'h0000_0010}, // R3
        {4'd1,  32'h8000_0000, 32'h0, 5'd31, 5'd0,  6'd0,  32'h0000_0001}, // R3
        {4'd2,  32'h8000_0000, 32'h0, 5'd4,  5'd0,  6'd0,  32'hF800_0000}, // R3
        {4'd2,  32'h8000_0000, 32'h0, 5'd0,  5'd0,  6'd0,  32'h8000_0000}, // R3
        {4'd3,  32'h8000_0001, 32'h0, 5'd1,  5'd0,  6'd0,  32'h0000_0003}, // R4
        {4'd4,  32'h0000_0001, 32'h0, 5'd1,  5'd0,  6'd0,  32'h8000_0000}, // R4
        {4'd5,  32'h1234_5678, 32'h9ABC_DEF0, 5'd8, 5'd0, 6'd0, 32'h3456_789A}, // R5
        {4'd6,  32'h1234_5678, 32'h9ABC_DEF0, 5'd8, 5'd0, 6'd0, 32'hF012_3456}, // R6
        {4'd5,  32'h1234_5678, 32'h9ABC_DEF0, 5'd0, 5'd0, 6'd0, 32'h1234_5678}, // R5
        {4'd7,  32'hDEAD_BEEF, 32'h0, 5'd0,  5'd8,  6'd8,  32'h0000_00BE}, // R7
        {4'd7,  32'hDEAD_BEEF, 32'h0, 5'd0,  5'd28, 6'd8,  32'h0000_000D}, // R7
        {4'd7,  32'hDEAD_BEEF, 32'h0, 5'd0,  5'd4,  6'd0,  32'h0000_0000}, // R7
        {4'd7,  32'hDEAD_BEEF, 32'h0, 5'd0,  5'd4,  6'd40, 32'h0DEA_DBEE}, // R7
        {4'd8,  32'h0000_00AB, 32'hFFFF_FFFF, 5'd0, 5'd4, 6'd8, 32'hFFFF_FABF}, // R8
        {4'd8,  32'h0000_000F, 32'h0, 5'd0,  5'd30, 6'd4,  32'hC000_0000}, // R8
        {4'd8,  32'hFFFF_FFFF, 32'h5555_5555, 5'd0, 5'd3, 6'd0, 32'h5555_5555}, // R8
        {4'd9,  32'h1122_3344, 32'h0, 5'd0,  5'd0,  6'd0,  32'h2211_4433}, // R9
        {4'd10, 32'h1122_3344, 32'h0, 5'd0,  5'd0,  6'd0,  32'h4433_2211}, // R9
        {4'd11, 32'h1122_3344, 32'h0, 5'd0,  5'd0,  6'd0,  32'h3344_1122}, // R9
        {4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 5'd3, 6'd3, 32'h0000_0000}  // R2
    };

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0, 4'd1, 4'd2: return "R3";
            4'd3, 4'd4:       return "R4";
            4'd5:             return "R5";
            4'd6:             return "R6";
            4'd7:             return "R7";
            4'd8:             return "R8";
            4'd9, 4'd10, 4'd11, 4'd12: return "R9";
            default:          return "R2";
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] x,
                                          input logic [31:0] y, input int n,
                                          input int p, input int l);
        logic [31:0] m, r;
        m = (l >= 32) ? 32'hFFFF_FFFF : ((32'h1 << l) - 32'h1);
        r = '0;
        case (o)
            4'd0:  r = x << n;
            4'd1:  r = x >> n;
            4'd2:  r = 32'($signed(x) >>> n);
            4'd3:  r = (x << n) | (x >> (32 - n));
            4'd4:  r = (x >> n) | (x << (32 - n));
            4'd5:  r = (x << n) | (y >> (32 - n));
            4'd6:  r = (x >> n) | (y << (32 - n));
            4'd7:  r = (x >> p) & m;
            4'd8:  r = (y & ~(m << p)) | ((x << p) & (m << p));
            4'd9:  r = {x[23:16], x[31:24], x[7:0], x[15:8]};
            4'd10: r = {x[7:0], x[15:8], x[23:16], x[31:24]};
            4'd11: r = {x[15:0], x[31:16]};
            4'd12: for (int i = 0; i < 32; i++) r[i] = x[31-i];
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input logic [31:0] exp, input string tag, input string what);
        n_run++;
        if (res !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %08h expected %08h", tag, what, res, exp);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                         input logic [4:0] n, input logic [4:0] p, input logic [5:0] l);
        @(negedge clk);
        op = o; a = x; b = y; amt = n; pos = p; len = l;
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        op = 4'd0; a = 32'h1; b = 32'h0; amt = 5'd1; pos = '0; len = '0;
        repeat (3) @(negedge clk);
        check(32'h0, "R1", "held in reset");
        rst_n = 1'b1;
        apply(4'd0, 32'h1, 32'h0, 5'd1, 5'd0, 6'd0);
        check(32'h2, "R1", "first result after reset");

        for (int v = 0; v < NV; v++) begin
            logic [115:0] e;
            e = VEC[v];
            apply(e[115:112], e[111:80], e[79:48], e[47:43], e[42:38], e[37:32]);
            check(e[31:0], tag_of(e[115:112]), $sformatf("vector %0d", v));
        end

        // BREV single bit, R9
        apply(4'd12, 32'h0000_0001, 32'h0, 5'd0, 5'd0, 6'd0);
        check(32'h8000_0000, "R9", "bit reversal");

        // every opcode, every amount, random operands
        for (int o = 0; o < 16; o++) begin
            for (int n = 0; n < 32; n++) begin
                logic [31:0] x, y;
                logic [5:0]  l;
                x = $urandom; y = $urandom; l = 6'($urandom_range(0, 40));
                apply(4'(o), x, y, 5'(n), 5'(n), l);
                check(model(4'(o), x, y, n, n, int'(l)), tag_of(4'(o)),
                      $sformatf("sweep op %0d n %0d", o, n));
            end
        end

        // funnel identities against plain shifts and rotates
        for (int n = 0; n < 32; n++) begin
            logic [31:0] x;
            x = $urandom | 32'h8000_0000;
            apply(4'd5, x, 32'h0, 5'(n), 5'd0, 6'd0);
            check(x << n, "R5", "FSL with zero fill equals SLL");
            apply(4'd5, x, x, 5'(n), 5'd0, 6'd0);
            check((x << n) | (x >> (32 - n)), "R5", "FSL with B=A equals ROL");
            apply(4'd6, x, x, 5'(n), 5'd0, 6'd0);
            check((x >> n) | (x << (32 - n)), "R6", "FSR with B=A equals ROR");
            apply(4'd6, x, 32'hFFFF_FFFF, 5'(n), 5'd0, 6'd0);
            check(32'($signed(x) >>> n), "R6", "FSR with sign fill equals SRA");
        end

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule